// File: doc/BRIEF.md
# Saturating Loop Accumulator

This block runs one counted loop in hardware and returns its value. A start request loads a signed starting value, a signed step and an unsigned trip count. Each clock cycle after that runs one iteration: the step is added to the running value at a wide internal width, and the sum is clamped into the signed range of the data width. When the trip count is used up, the final value goes to the result output together with a one-cycle done pulse. The result then holds until the next accepted start.

Inside, the loop follows a dependence-graph mapping. A loop-carried merge stage takes the starting value, the value carried from the previous iteration and the loop predicate (index below trip count). It sends the carried value either into the iteration body or to the exit output. Two comparison predicates, over-upper and under-lower, steer a three-way clamp multiplexer. The running value is held in a register, so it is correct whichever clamp path was taken.

Control pins are plain level signals, with no valid/ready pair. The block never applies back-pressure. Start is taken only in a cycle where busy is low, and a start seen while busy is high is dropped. The caller must hold the result until done and read it in or after the done cycle. The data inputs are sampled only in the cycle that start is taken.

Top module: `sat_loop_acc`

## Requirements
- R1: A synchronous active-high reset drives busy to 0, done to 0 and result to 0.
- R2: When start is high and busy is low at a clock edge, busy is 1 after that edge. The starting value, step and trip count are captured at that same edge.
- R3: A trip count of 0 returns the starting value unchanged.
- R4: Each iteration sets the running value to the running value plus the signed step, when that sum lies inside the signed DATA_W range.
- R5: The upper test is applied first. A sum greater than 2^(DATA_W-1)-1 (32767 at the default width) becomes exactly that bound.
- R6: A sum that passes the upper test but is below -2^(DATA_W-1) (-32768 at the default width) becomes exactly that bound.
- R7: One iteration runs per cycle. For trip count L, done is 1 in the cycle that follows the (L+1)-th edge after the accepting edge. Busy stays 1 from the accepting edge until that point and is 0 when done is 1.
- R8: Done is high for exactly one cycle. Result changes only in a done cycle and otherwise holds its value.
- R9: A start that arrives while busy is 1 is ignored: neither the running loop's result nor its latency changes.
- R10: The trip count is unsigned. A count with its top bit set (for example 40000 at LEN_W=16) runs that many iterations.
- R11: Changes on the starting-value, step and trip-count inputs while busy is 1 have no effect on the running loop.
- R12: The clamp bounds follow DATA_W. The sum is formed at SUM_W bits, so it cannot wrap before the clamp tests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a loop; taken when busy is low |
| init_val | input | DATA_W | Signed starting value |
| inc_val | input | INC_W | Signed step added each iteration |
| loop_len | input | LEN_W | Unsigned trip count |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | DATA_W | Signed final value, held until the next start |

## Verification
The bench builds two instances. The first uses the default widths: 16-bit data and step, a 32-bit sum and a 16-bit count. It is driven with directed runs that cover both clamp bounds, a zero count, a start while busy, and a count of 40000, which would look negative if the count were read as signed. The second instance uses 4-bit data and step, an 8-bit sum and a 3-bit count. This makes it possible to sweep every starting value, every step and every trip count. The result and latency of each sweep run are compared against an arithmetic model of add-then-clamp.

// File: rtl/sla_pkg.sv
package sla_pkg;
  // which value the clamp merge commits
  typedef enum logic [1:0] {
    SEL_SUM = 2'd0,
    SEL_HI  = 2'd1,
    SEL_LO  = 2'd2
  } clamp_sel_e;
endpackage

// File: rtl/sla_clamp.sv
module sla_clamp #(
  parameter int DATA_W = 16,
  parameter int INC_W  = 16,
  parameter int SUM_W  = 32
) (
  input  logic [DATA_W-1:0] acc_in,
  input  logic [INC_W-1:0]  inc_in,
  output logic [DATA_W-1:0] next_val
);
  import sla_pkg::*;

  localparam int PAD_A = SUM_W - DATA_W;
  localparam int PAD_I = SUM_W - INC_W;
  localparam logic signed [SUM_W-1:0] HI_B = SUM_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] LO_B = ~HI_B;

  logic signed [SUM_W-1:0] sum;
  logic pred_hi, pred_lo;
  clamp_sel_e sel;

  // wide add: cannot wrap before the bound tests
  assign sum = {{PAD_A{acc_in[DATA_W-1]}}, acc_in} + {{PAD_I{inc_in[INC_W-1]}}, inc_in};

  // predicate nodes
  assign pred_hi = sum > HI_B;
  assign pred_lo = sum < LO_B;

  // upper test has priority
  always_comb begin
    if (pred_hi)      sel = SEL_HI;
    else if (pred_lo) sel = SEL_LO;
    else              sel = SEL_SUM;
  end

  // three-input merge
  always_comb begin
    case (sel)
      SEL_HI:  next_val = HI_B[DATA_W-1:0];
      SEL_LO:  next_val = LO_B[DATA_W-1:0];
      default: next_val = sum[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/sla_carry_merge.sv
module sla_carry_merge #(
  parameter int DATA_W = 16
) (
  input  logic              load,
  input  logic              active,
  input  logic              loop_pred,
  input  logic [DATA_W-1:0] entry_val,
  input  logic [DATA_W-1:0] carried_val,
  output logic [DATA_W-1:0] body_val,
  output logic              body_take,
  output logic [DATA_W-1:0] exit_val,
  output logic              exit_take
);
  logic [DATA_W-1:0] merged;

  // entry value on load, carried value otherwise
  assign merged    = load ? entry_val : carried_val;

  // switch: predicate routes the merged value to body or exit
  assign body_val  = merged;
  assign exit_val  = merged;
  assign body_take = active && !load && loop_pred;
  assign exit_take = active && !load && !loop_pred;
endmodule

// File: rtl/sla_ctrl.sv
module sla_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] loop_len,
  output logic             busy,
  output logic             done,
  output logic             load,
  output logic             loop_pred
);
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;

  assign load      = start && !busy;
  assign loop_pred = idx_q < len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        idx_q <= '0;
        len_q <= loop_len;
      end else if (busy) begin
        if (loop_pred) begin
          idx_q <= idx_q + LEN_W'(1);
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sat_loop_acc.sv
module sat_loop_acc #(
  parameter int DATA_W = 16,
  parameter int INC_W  = 16,
  parameter int SUM_W  = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] init_val,
  input  logic [INC_W-1:0]  inc_val,
  input  logic [LEN_W-1:0]  loop_len,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic              load, loop_pred;
  logic              body_take, exit_take;
  logic [DATA_W-1:0] acc_q, body_val, exit_val, next_val, result_q;
  logic [INC_W-1:0]  inc_q;

  sla_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .loop_len(loop_len),
    .busy(busy), .done(done), .load(load), .loop_pred(loop_pred)
  );

  sla_carry_merge #(.DATA_W(DATA_W)) u_merge (
    .load(load), .active(busy), .loop_pred(loop_pred),
    .entry_val(init_val), .carried_val(acc_q),
    .body_val(body_val), .body_take(body_take),
    .exit_val(exit_val), .exit_take(exit_take)
  );

  sla_clamp #(.DATA_W(DATA_W), .INC_W(INC_W), .SUM_W(SUM_W)) u_clamp (
    .acc_in(body_val), .inc_in(inc_q), .next_val(next_val)
  );

  // carried-value and operand registers
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      inc_q    <= '0;
      result_q <= '0;
    end else begin
      if (load) begin
        acc_q <= body_val;
        inc_q <= inc_val;
      end else if (body_take) begin
        acc_q <= next_val;
      end
      if (exit_take) result_q <= exit_val;
    end
  end

  assign result = result_q;
endmodule

// File: rtl/sla_checker.sv
module sla_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      a_r1_reset_clears: assert (!busy && !done && result == '0);
    end
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r7_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind sat_loop_acc sla_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/sat_loop_acc_tb.sv
module sat_loop_acc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // default-width instance
  logic        b_start = 1'b0;
  logic [15:0] b_init = '0, b_inc = '0, b_len = '0;
  logic        b_busy, b_done;
  logic [15:0] b_result;

  sat_loop_acc u_dut (
    .clk(clk), .rst(rst), .start(b_start), .init_val(b_init), .inc_val(b_inc),
    .loop_len(b_len), .busy(b_busy), .done(b_done), .result(b_result)
  );

  // small instance for exhaustive sweep
  logic       s_start = 1'b0;
  logic [3:0] s_init = '0, s_inc = '0;
  logic [2:0] s_len = '0;
  logic       s_busy, s_done;
  logic [3:0] s_result;

  sat_loop_acc #(.DATA_W(4), .INC_W(4), .SUM_W(8), .LEN_W(3)) u_small (
    .clk(clk), .rst(rst), .start(s_start), .init_val(s_init), .inc_val(s_inc),
    .loop_len(s_len), .busy(s_busy), .done(s_done), .result(s_result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int iv, input int dv, input int ln,
                               input int hi, input int lo);
    int v = iv;
    for (int k = 0; k < ln; k++) begin
      v = v + dv;
      if (v > hi) v = hi;
      else if (v < lo) v = lo;
    end
    return v;
  endfunction

  task automatic run_big(input int iv, input int dv, input int ln,
                         input string req, input bit disturb);
    int exp, cnt, held;
    exp = model(iv, dv, ln, 32767, -32768);
    @(negedge clk);
    b_start = 1'b1; b_init = iv[15:0]; b_inc = dv[15:0]; b_len = ln[15:0];
    @(negedge clk);
    b_start = 1'b0;
    chk(b_busy == 1'b1, "R2 busy after accept", int'(b_busy), 1);
    if (disturb) begin
      // R9 R11: new start and new operands while busy
      b_start = 1'b1; b_init = 16'h1234; b_inc = 16'h0100; b_len = 16'd3;
    end
    cnt = 0;
    while (!b_done) begin
      @(negedge clk);
      cnt++;
      b_start = 1'b0;
      if (!disturb) begin
        b_init = ~b_init; b_inc = ~b_inc; b_len = ~b_len;
      end
    end
    chk(cnt == ln + 1, "R7 latency", cnt, ln + 1);
    chk(int'($signed(b_result)) == exp, req, int'($signed(b_result)), exp);
    held = int'($signed(b_result));
    @(negedge clk);
    chk(b_done == 1'b0, "R8 done one cycle", int'(b_done), 0);
    repeat (3) @(negedge clk);
    chk(int'($signed(b_result)) == held, "R8 result holds", int'($signed(b_result)), held);
  endtask

  task automatic run_small(input int iv, input int dv, input int ln);
    int exp, cnt;
    exp = model(iv, dv, ln, 7, -8);
    @(negedge clk);
    s_start = 1'b1; s_init = iv[3:0]; s_inc = dv[3:0]; s_len = ln[2:0];
    @(negedge clk);
    s_start = 1'b0;
    cnt = 0;
    while (!s_done) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == ln + 1, "R12 R7 sweep latency", cnt, ln + 1);
    chk(int'($signed(s_result)) == exp, "R12 sweep value", int'($signed(s_result)), exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 160000) begin
      failures++;
      checks++;
      $display("FAIL R7 watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(b_busy == 1'b0 && b_done == 1'b0, "R1 reset flags", int'({b_busy, b_done}), 0);
    chk(b_result == 16'd0, "R1 reset result", int'(b_result), 0);
    chk(s_busy == 1'b0 && s_result == 4'd0, "R1 small reset", int'(s_result), 0);
    rst = 1'b0;
    @(negedge clk);

    run_big(1234, 5, 0, "R3 zero count", 1'b0);
    run_big(-32768, 77, 0, "R3 zero count min", 1'b0);
    run_big(100, 7, 10, "R4 plain add", 1'b0);
    run_big(-50, -3, 20, "R4 negative step", 1'b0);
    run_big(32767, -1, 3, "R4 down from top", 1'b0);
    run_big(32000, 100, 10, "R5 upper clamp", 1'b0);
    run_big(32767, 32767, 3, "R5 R12 wide sum", 1'b0);
    run_big(-32000, -100, 10, "R6 lower clamp", 1'b0);
    run_big(-32768, -32768, 5, "R6 R12 wide sum", 1'b0);
    run_big(-32768, 300, 4, "R4 up from bottom", 1'b0);
    run_big(10, 3, 5, "R9 R11 busy start ignored", 1'b1);
    run_big(7, -2, 0, "R9 R11 zero count disturbed", 1'b1);
    run_big(0, 1, 40000, "R10 unsigned count", 1'b0);

    for (int iv = -8; iv < 8; iv++)
      for (int dv = -8; dv < 8; dv++)
        for (int ln = 0; ln < 8; ln++)
          run_small(iv, dv, ln);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule